// File: doc/BRIEF.md
# Saturating DSP Add/Subtract Unit

This block is the arithmetic core for saturating signed add and subtract operations on 32-bit two's-complement data. It supports four operations: plain add, plain subtract, doubled add and doubled subtract. In the doubled forms the second operand is multiplied by two with saturation, and the result is then added to or subtracted from the first operand, again with saturation. No result ever wraps. A positive overflow clamps to 0x7FFFFFFF and a negative overflow clamps to 0x80000000.

The result path is purely combinational. It is meaningful whenever the valid strobe is high. A single sticky saturation flag is registered. Either saturation stage can set it: the doubling stage or the final add/subtract stage. Operations never clear it. Only a dedicated synchronous clear input lowers it. If a clear and a set land in the same cycle, the set wins. Instruction decode and register write-back sit outside this block, which sees only operand values and the two operation selects.

Top module: `dsp_qaddsub`

## Requirements
- R1: With `sub_i`=0 and `dbl_i`=0, `res_o` equals the signed sum of `op_a_i` and `op_b_i`. A sum above 2^31-1 gives 0x7FFFFFFF and a sum below -2^31 gives 0x80000000.
- R2: With `sub_i`=1 and `dbl_i`=0, `res_o` equals `op_a_i` minus `op_b_i`, with the same clamping as R1.
- R3: With `dbl_i`=1, the second operand is first replaced by twice its value, clamped to 0x7FFFFFFF if `op_b_i` is at least 2^30 and to 0x80000000 if `op_b_i` is below -2^30.
- R4: With `dbl_i`=1, `res_o` is the saturating sum (`sub_i`=0) or difference (`sub_i`=1) of `op_a_i` and the doubled value from R3.
- R5: A clock edge with `valid_i`=1 and a saturating final add or subtract sets `sat_flag_o` from the next cycle on.
- R6: A clock edge with `valid_i`=1, `dbl_i`=1 and a saturating doubling step sets `sat_flag_o`, even when the final add or subtract does not saturate.
- R7: Once set, `sat_flag_o` stays set across later operations that do not saturate. Saturation is detected from signs and not by value, so an exact result of 0x7FFFFFFF does not set the flag.
- R8: A clock edge with `clr_i`=1 clears `sat_flag_o` unless the same edge also sets it under R5 or R6, in which case the flag is set.
- R9: A clock edge with `valid_i`=0 leaves `sat_flag_o` unchanged by the operands, even when they would saturate.
- R10: While `rst_ni` is low, `sat_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; the flag updates on edges where it is high |
| sub_i | input | 1 | 1 selects first operand minus second operand |
| dbl_i | input | 1 | 1 selects the doubled form of the second operand |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| op_a_i | input | 32 | First signed operand |
| op_b_i | input | 32 | Second signed operand |
| res_o | output | 32 | Saturated signed result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `valid_i`, `clr_i` and the selects are known, settled values at each rising edge. The flag properties also assume that the operands are stable around that edge, so that the saturation seen combinationally matches what the register captured. The bench meets these assumptions by changing every input only on the falling edge and holding it through the following rising edge. Between operations it returns `valid_i` and `clr_i` to zero, so the hold and stickiness properties are exercised during idle cycles as well.

// File: rtl/dsp_qaddsub_pkg.sv
package dsp_qaddsub_pkg;

    // Registered state of the unit: only the sticky saturation indicator.
    typedef struct packed {
        logic sticky;
    } flag_state_t;

    // Operation encoding formed from {sub, dbl} for readability inside the datapath.
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_DADD = 2'b01,
        OP_SUB  = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

endpackage

// File: rtl/dsp_sat_double.sv
module dsp_sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dbl_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    // Shifting left by one overflows exactly when the two top bits differ.
    always_comb begin
        ovf_o = val_i[W-1] ^ val_i[W-2];
        if (ovf_o) begin
            dbl_o = val_i[W-1] ? SAT_MIN : SAT_MAX;
        end else begin
            dbl_o = {val_i[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/dsp_sat_addsub.sv
module dsp_sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] raw;

    // One guard bit: the sign of the true result is raw[W]; overflow when it
    // disagrees with the truncated sign raw[W-1].
    always_comb begin
        a_ext = {a_i[W-1], a_i};
        b_ext = {b_i[W-1], b_i};
        raw   = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
        ovf_o = raw[W] ^ raw[W-1];
        if (ovf_o) begin
            y_o = raw[W] ? SAT_MIN : SAT_MAX;
        end else begin
            y_o = raw[W-1:0];
        end
    end

endmodule

// File: rtl/dsp_qaddsub.sv
module dsp_qaddsub
    import dsp_qaddsub_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         valid_i,
    input  logic         sub_i,
    input  logic         dbl_i,
    input  logic         clr_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic [W-1:0] res_o,
    output logic         sat_flag_o
);
    sat_op_e     op;
    logic [W-1:0] dbl_val;
    logic         dbl_ovf;
    logic         dbl_hit;
    logic [W-1:0] rhs;
    logic         fin_ovf;
    logic         any_sat;
    flag_state_t  st_d, st_q;

    assign op = sat_op_e'({sub_i, dbl_i});

    // Stage 1: saturating doubling of the second operand.
    dsp_sat_double #(.W(W)) i_double (
        .val_i (op_b_i),
        .dbl_o (dbl_val),
        .ovf_o (dbl_ovf)
    );

    // Stage 2: saturating add or subtract.
    dsp_sat_addsub #(.W(W)) i_addsub (
        .a_i   (op_a_i),
        .b_i   (rhs),
        .sub_i (sub_i),
        .y_o   (res_o),
        .ovf_o (fin_ovf)
    );

    always_comb begin
        st_d    = st_q;
        dbl_hit = 1'b0;
        rhs     = op_b_i;
        unique case (op)
            OP_DADD, OP_DSUB: begin
                rhs     = dbl_val;
                dbl_hit = dbl_ovf;
            end
            default: begin
                rhs     = op_b_i;
                dbl_hit = 1'b0;
            end
        endcase
        any_sat = valid_i & (dbl_hit | fin_ovf);
        if (any_sat) begin
            st_d.sticky = 1'b1;
        end else if (clr_i) begin
            st_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sat_flag_o = st_q.sticky;

    // Two non-negative addends never give a negative sum (R1).
    p_add_nonneg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !dbl_i && !sub_i && !op_a_i[W-1] && !op_b_i[W-1]) |-> !res_o[W-1]);

    // Doubling keeps the sign of its input (R3).
    p_dbl_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbl_i |-> (dbl_val[W-1] == op_b_i[W-1]));

    // Final-stage saturation raises the flag (R5).
    p_final_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && fin_ovf) |=> sat_flag_o);

    // Doubling saturation alone raises the flag (R6).
    p_dbl_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && dbl_i && dbl_ovf) |=> sat_flag_o);

    // Without a clear the flag never falls (R7).
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sat_flag_o && !clr_i) |=> sat_flag_o);

    // A clear with no operation empties the flag (R8).
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !valid_i) |=> !sat_flag_o);

    // No strobe and no clear: flag holds (R9).
    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_i && !clr_i) |=> $stable(sat_flag_o));

endmodule

// File: tb/test_dsp_qaddsub.sv
module test_dsp_qaddsub;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        valid_i = 1'b0;
    logic        sub_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [31:0] res_o;
    logic        sat_flag_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  exp_flag = 1'b0;
    bit  done = 1'b0;

    always #2 clk_i = ~clk_i;

    dsp_qaddsub i_dsp_qaddsub (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (valid_i),
        .sub_i      (sub_i),
        .dbl_i      (dbl_i),
        .clr_i      (clr_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .res_o      (res_o),
        .sat_flag_o (sat_flag_o)
    );

    localparam longint LMAX = 64'sd2147483647;
    localparam longint LMIN = -64'sd2147483648;

    function automatic longint clamp(input longint x, output bit hit);
        hit = 1'b0;
        if (x > LMAX) begin hit = 1'b1; return LMAX; end
        if (x < LMIN) begin hit = 1'b1; return LMIN; end
        return x;
    endfunction

    task automatic check_res(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: res actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_flag(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: flag actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Apply one cycle of stimulus, check result and the flag afterwards.
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input bit sub, input bit dbl, input bit vld, input bit clr);
        longint la, lb, rhs, fin;
        bit h1, h2;
        @(negedge clk_i);
        op_a_i = a; op_b_i = b; sub_i = sub; dbl_i = dbl; valid_i = vld; clr_i = clr;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        h1 = 1'b0;
        rhs = dbl ? clamp(lb * 2, h1) : lb;
        fin = clamp(sub ? la - rhs : la + rhs, h2);
        #1;
        check_res(req, res_o, fin[31:0]);
        if (vld && (h1 || h2)) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        @(posedge clk_i);
        #1;
        check_flag(req, sat_flag_o, exp_flag);
        valid_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check_flag("R10", sat_flag_o, 1'b0);
        repeat (2) @(negedge clk_i);
        check_flag("R10", sat_flag_o, 1'b0);
        rst_ni = 1'b1;
    endtask

    task automatic t_plain;
        run_op("R1", 32'd5, 32'd7, 0, 0, 1, 0);
        run_op("R1", 32'hFFFF_FFF6, 32'd3, 0, 0, 1, 0);
        run_op("R7", 32'h7FFF_FFFE, 32'd1, 0, 0, 1, 0);   // exact max, no flag
        run_op("R2", 32'd100, 32'd250, 1, 0, 1, 0);
        run_op("R2", 32'h8000_0001, 32'd1, 1, 0, 1, 0);   // exact min, no flag
        check_flag("R7", sat_flag_o, 1'b0);
    endtask

    task automatic t_final_sat;
        run_op("R5", 32'h7FFF_FFF0, 32'h0000_0020, 0, 0, 1, 0);
        check_res("R1", res_o, 32'h7FFF_FFFF);
        run_op("R8", 32'd0, 32'd0, 0, 0, 0, 1);
        run_op("R5", 32'h8000_0000, 32'd1, 1, 0, 1, 0);
        check_res("R2", res_o, 32'h8000_0000);
        run_op("R2", 32'h7FFF_FFFF, 32'h8000_0000, 1, 0, 1, 0);
        run_op("R7", 32'd1, 32'd2, 0, 0, 1, 0);           // still set
        run_op("R8", 32'd0, 32'd0, 0, 0, 0, 1);
    endtask

    task automatic t_double;
        run_op("R3", 32'd0, 32'h3FFF_FFFF, 0, 1, 1, 0);   // 2b fits
        run_op("R4", 32'd10, 32'hFFFF_FFFB, 1, 1, 1, 0);  // 10 - (-10)
        run_op("R6", 32'hC000_0000, 32'h4000_0000, 0, 1, 1, 0); // dbl sat only
        check_res("R3", res_o, 32'h3FFF_FFFF);
        run_op("R8", 32'd0, 32'd0, 0, 1, 0, 1);
        run_op("R3", 32'd0, 32'hC000_0000, 0, 1, 1, 0);   // -2^30 doubles exactly
        run_op("R6", 32'h8000_0000, 32'hBFFF_FFFF, 1, 1, 1, 0); // dbl clamps low
        check_res("R4", res_o, 32'h0000_0000);
        run_op("R8", 32'd0, 32'd0, 0, 0, 0, 1);
        run_op("R4", 32'd10, 32'hBFFF_FFFF, 1, 1, 1, 0);
        run_op("R8", 32'd0, 32'd0, 0, 0, 0, 1);
    endtask

    task automatic t_gating;
        run_op("R9", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0);
        run_op("R9", 32'd0, 32'h4000_0000, 0, 1, 0, 0);
        check_flag("R9", sat_flag_o, 1'b0);
        run_op("R8", 32'h7FFF_FFFF, 32'd5, 0, 0, 1, 1);   // set beats clear
        run_op("R8", 32'd1, 32'd1, 0, 0, 1, 1);           // clear with valid op
        run_op("R9", 32'h8000_0000, 32'd9, 1, 0, 0, 1);   // clear, op not valid
    endtask

    initial begin
        t_reset();
        t_plain();
        t_final_sat();
        t_double();
        t_gating();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule